// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block drives one asynchronous serial line from a byte stream. A byte comes in through a valid/ready handshake and waits in a one-word holding register. When the shift stage is free, the byte moves into it and goes out least significant bit first. The frame is a start bit, then the data bits, then an optional parity bit, then the stop bits. Bit timing comes from an oversampling tick that the chip supplies at sixteen times the bit rate. Each regular bit lasts sixteen ticks, and a half stop bit lasts eight.

The frame format comes from an 8-bit line-control byte. It selects the word length, the parity mode, the stop length and a break override. The format is captured at the start of each frame, so a frame in flight keeps the format it started with. The break bit is the exception: it acts immediately. An optional clear-to-send gate can hold back the start of a new frame. The block reports whether the holding register has room and whether the whole transmitter is empty.

Top module: `lcr_uart_tx`

## Requirements
- R1: Control bits [1:0] set the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant first, after a start bit at 0, and any data bits above the word length are not sent. Control bit 7 has no effect.
- R2: Control bit 3 enables a parity bit between the last data bit and the stop bits. With bit 5 clear, bit 4 = 1 gives even parity and bit 4 = 0 gives odd parity. Parity is computed over the sent data bits only.
- R3: With bits 3 and 5 both set, the parity bit is a constant: 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R4: Stop bits are at 1. With bit 2 clear, the stop time is 16 ticks. With bit 2 set, it is 24 ticks for 5-bit words and 32 ticks for longer words. Frames queued back to back start exactly one frame length apart: 16 x (1 + word length + parity) + stop ticks.
- R5: While control bit 6 is set, the line output is 0 from the next clock on, and this holds even in the middle of a frame.
- R6: A frame cut off by break is dropped and is never resent. After break clears, the line stays at 1 for at least 16 ticks before any new start bit. A byte that was waiting in the holding register is kept and sent afterwards.
- R7: `tx_ready_o` is high exactly when the holding register is empty, and it falls in the cycle after a byte is accepted. It rises again when that byte moves into the shift stage, while the shift is still running. `temt_o` is high only when both the holding register and the shift stage are empty.
- R8: When `cts_gate_en_i` is 1, a frame starts only while `cts_i` is 1. A frame that has already started always completes, even if `cts_i` drops.
- R9: When `cts_gate_en_i` is 0, `cts_i` has no effect.
- R10: After reset the line output is 1, `tx_ready_o` is 1 and `temt_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick_i | input | 1 | One-cycle tick at 16x the bit rate |
| lcr_i | input | 8 | Line-control byte (word length, stop, parity, break) |
| cts_gate_en_i | input | 1 | Enables gating of frame starts by clear-to-send |
| cts_i | input | 1 | Clear-to-send, active high |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Holding register empty; a byte is accepted when valid and ready are both high |
| txd_o | output | 1 | Serial line, idle 1 |
| temt_o | output | 1 | Holding register and shift stage both empty |

## Verification
The serial output is decoded by counting the bench's own ticks from each start edge and sampling mid-bit. Directed frames are sent at each of the four word lengths, with even, odd and both constant parity modes. These separate the masking of the word from the parity arithmetic. Pairs of queued frames measure the spacing between start edges under the 1, 1.5 and 2 stop settings. Only this spacing shows a wrong stop length, because a single frame looks correct when sampled mid-bit. Random control bytes, with bit 7 also random, random data and tick rates of one tick every one to three cycles, test the same decoding across many format mixes. Further directed runs cover break in the middle of a frame with a byte waiting, a held-back frame under the clear-to-send gate with the signal dropped mid-frame, and the ready and empty flags around a single byte.

// File: rtl/lcr_tx_pkg.sv
package lcr_tx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WCNT_W = 4;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_mode_e;

  typedef struct packed {
    logic [WCNT_W-1:0] nbits;
    logic              par_en;
    logic              par_stick;
    logic              par_even;
    stop_mode_e        stop;
    logic              brk;
  } tx_fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_GUARD = 3'd5
  } tx_state_e;

  // Mask keeping the lowest nbits of a byte
  function automatic logic [BYTE_W-1:0] word_mask(input logic [WCNT_W-1:0] nbits);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i] = (i < int'(nbits));
    end
    return m;
  endfunction

  // Parity bit for a frame, over the sent data bits only
  function automatic logic frame_parity(input logic [BYTE_W-1:0] data,
                                        input tx_fmt_t fmt);
    logic [BYTE_W-1:0] kept;
    kept = data & word_mask(fmt.nbits);
    if (fmt.par_stick) begin
      return ~fmt.par_even;
    end
    return fmt.par_even ? ^kept : ~^kept;
  endfunction

endpackage

// File: rtl/lcr_tx_fmt.sv
module lcr_tx_fmt
  import lcr_tx_pkg::*;
(
  input  logic [7:0] lcr_i,
  output tx_fmt_t    fmt_o
);

  logic unused_bit7;
  assign unused_bit7 = lcr_i[7];

  always_comb begin
    fmt_o.nbits     = WCNT_W'(5) + {2'b00, lcr_i[1:0]};
    fmt_o.par_en    = lcr_i[3];
    fmt_o.par_even  = lcr_i[4];
    fmt_o.par_stick = lcr_i[5];
    fmt_o.brk       = lcr_i[6];
    if (!lcr_i[2]) begin
      fmt_o.stop = STOP_ONE;
    end else if (lcr_i[1:0] == 2'b00) begin
      fmt_o.stop = STOP_ONE_HALF;
    end else begin
      fmt_o.stop = STOP_TWO;
    end
  end

endmodule

// File: rtl/lcr_tx_hold.sv
module lcr_tx_hold
  import lcr_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] data_o
);

  logic              full_q, full_d;
  logic [BYTE_W-1:0] data_q;
  logic              accept;

  assign accept = valid_i & ~full_q;

  always_comb begin
    full_d = full_q;
    if (take_i) begin
      full_d = 1'b0;
    end else if (accept) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      data_q <= data_i;
    end
  end

  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;

endmodule

// File: rtl/lcr_tx_shift.sv
module lcr_tx_shift
  import lcr_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  tx_fmt_t           fmt_i,
  input  logic              hold_full_i,
  input  logic [BYTE_W-1:0] hold_data_i,
  input  logic              cts_ok_i,
  output logic              take_o,
  output logic              line_o,
  output logic              idle_o
);

  localparam int unsigned TICK_W = $clog2(2 * OVERSAMPLE);
  localparam logic [TICK_W-1:0] BIT_LAST     = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] ONEHALF_LAST = TICK_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] TWO_LAST     = TICK_W'(2 * OVERSAMPLE - 1);

  tx_state_e         state_q, state_d;
  logic [TICK_W-1:0] tcnt_q, tcnt_d;
  logic [WCNT_W-1:0] bcnt_q, bcnt_d;
  logic [WCNT_W-1:0] nlast_q, nlast_d;
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic [TICK_W-1:0] slast_q, slast_d;
  logic              can_start, bit_end, take;
  logic [TICK_W-1:0] stop_last_new;

  assign can_start = hold_full_i & cts_ok_i & ~fmt_i.brk;
  assign bit_end   = tick_i && (tcnt_q == BIT_LAST);

  always_comb begin
    unique case (fmt_i.stop)
      STOP_ONE_HALF: stop_last_new = ONEHALF_LAST;
      STOP_TWO:      stop_last_new = TWO_LAST;
      default:       stop_last_new = BIT_LAST;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    tcnt_d  = tick_i ? tcnt_q + TICK_W'(1) : tcnt_q;
    bcnt_d  = bcnt_q;
    nlast_d = nlast_q;
    sreg_d  = sreg_q;
    par_d   = par_q;
    pen_d   = pen_q;
    slast_d = slast_q;
    take    = 1'b0;
    if (fmt_i.brk) begin
      state_d = ST_GUARD;
      tcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tcnt_d = '0;
          take   = can_start;
        end
        ST_GUARD: begin
          if (bit_end) begin
            state_d = ST_IDLE;
            tcnt_d  = '0;
          end
        end
        ST_START: begin
          if (bit_end) begin
            state_d = ST_DATA;
            tcnt_d  = '0;
            bcnt_d  = '0;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            tcnt_d = '0;
            sreg_d = sreg_q >> 1;
            if (bcnt_q == nlast_q) begin
              state_d = pen_q ? ST_PAR : ST_STOP;
            end else begin
              bcnt_d = bcnt_q + WCNT_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            state_d = ST_STOP;
            tcnt_d  = '0;
          end
        end
        ST_STOP: begin
          if (tick_i && (tcnt_q == slast_q)) begin
            tcnt_d = '0;
            if (can_start) begin
              take = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          tcnt_d  = '0;
        end
      endcase
    end
    if (take) begin
      state_d = ST_START;
      tcnt_d  = '0;
      sreg_d  = hold_data_i;
      par_d   = frame_parity(hold_data_i, fmt_i);
      nlast_d = fmt_i.nbits - WCNT_W'(1);
      pen_d   = fmt_i.par_en;
      slast_d = stop_last_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      nlast_q <= '0;
      sreg_q  <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      slast_q <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      nlast_q <= nlast_d;
      sreg_q  <= sreg_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
      slast_q <= slast_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign take_o = take;
  assign idle_o = (state_q == ST_IDLE);

endmodule

// File: rtl/lcr_uart_tx.sv
module lcr_uart_tx
  import lcr_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic [7:0] lcr_i,
  input  logic       cts_gate_en_i,
  input  logic       cts_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       txd_o,
  output logic       temt_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  tx_fmt_t           fmt;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              take;
  logic              line_bit;
  logic              shift_idle;
  logic              cts_ok;
  logic              txd_q, txd_d;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign cts_ok = ~cts_gate_en_i | cts_i;

  lcr_tx_fmt fmt_i (
    .lcr_i (lcr_i),
    .fmt_o (fmt)
  );

  lcr_tx_hold hold_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .take_i  (take),
    .ready_o (tx_ready_o),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  lcr_tx_shift #(
    .OVERSAMPLE (OVERSAMPLE)
  ) shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .tick_i      (baud_tick_i),
    .fmt_i       (fmt),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .cts_ok_i    (cts_ok),
    .take_o      (take),
    .line_o      (line_bit),
    .idle_o      (shift_idle)
  );

  assign txd_d = fmt.brk ? 1'b0 : line_bit;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= txd_d;
    end
  end

  assign txd_o  = txd_q;
  assign temt_o = ~hold_full & shift_idle;

endmodule

// File: rtl/lcr_uart_tx_chk.sv
module lcr_uart_tx_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic [7:0] lcr_i,
  input logic       cts_gate_en_i,
  input logic       cts_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       txd_o,
  input logic       temt_o,
  input logic       take
);

  // R7
  temt_has_room_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    temt_o |-> tx_ready_o);

  // R7
  accept_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R5
  break_space_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    lcr_i[6] |=> !txd_o);

  // R8
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (take && cts_gate_en_i) |-> cts_i);

  // R6
  release_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(lcr_i[6]) |-> !take);

endmodule

bind lcr_uart_tx lcr_uart_tx_chk chk_i (
  .clk_i         (clk_i),
  .rst_n         (rst_sync_n),
  .lcr_i         (lcr_i),
  .cts_gate_en_i (cts_gate_en_i),
  .cts_i         (cts_i),
  .tx_valid_i    (tx_valid_i),
  .tx_ready_o    (tx_ready_o),
  .txd_o         (txd_o),
  .temt_o        (temt_o),
  .take          (take)
);

// File: tb/lcr_uart_tx_tb_top.sv
`timescale 1ns/1ps
module lcr_uart_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [7:0] lcr;
  logic       cts_gate_en;
  logic       cts;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       txd;
  logic       temt;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_count = 0;
  int tick_div = 1;
  int div_cnt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  lcr_uart_tx dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .baud_tick_i   (baud_tick),
    .lcr_i         (lcr),
    .cts_gate_en_i (cts_gate_en),
    .cts_i         (cts),
    .tx_data_i     (tx_data),
    .tx_valid_i    (tx_valid),
    .tx_ready_o    (tx_ready),
    .txd_o         (txd),
    .temt_o        (temt)
  );

  initial baud_tick = 1'b0;
  always @(negedge clk) begin
    if (div_cnt + 1 >= tick_div) begin
      div_cnt   = 0;
      baud_tick = 1'b1;
    end else begin
      div_cnt   = div_cnt + 1;
      baud_tick = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (baud_tick) tick_count = tick_count + 1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int nbits_of(input logic [7:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic logic [7:0] mask_of(input logic [7:0] l);
    return 8'hFF >> (2'd3 - l[1:0]);
  endfunction

  function automatic logic exp_par(input logic [7:0] l, input logic [7:0] d);
    logic [7:0] m;
    m = d & mask_of(l);
    if (l[5]) return ~l[4];
    return l[4] ? ^m : ~^m;
  endfunction

  function automatic int frame_ticks(input logic [7:0] l);
    int stop;
    if (!l[2]) stop = 16;
    else if (l[1:0] == 2'b00) stop = 24;
    else stop = 32;
    return 16 * (1 + nbits_of(l) + int'(l[3])) + stop;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (tick_count < t) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Decodes one frame at mid-bit; returns tick count at the start edge
  task automatic recv(input logic [7:0] l, output logic [7:0] d, output logic p,
                      output bit fr_ok, output int t_edge);
    int g;
    int k;
    g = 0; d = '0; p = 1'b0; fr_ok = 1'b0; t_edge = 0;
    while (txd !== 1'b0) begin
      @(negedge clk);
      g = g + 1;
      if (g > 30000) return;
    end
    t_edge = tick_count;
    wait_until(t_edge + 8);
    fr_ok = (txd == 1'b0);
    for (int i = 0; i < nbits_of(l); i++) begin
      wait_until(t_edge + 8 + 16 * (i + 1));
      d[i] = txd;
    end
    k = nbits_of(l) + 1;
    if (l[3]) begin
      wait_until(t_edge + 8 + 16 * k);
      p = txd;
      k = k + 1;
    end
    wait_until(t_edge + 8 + 16 * k);
    fr_ok = fr_ok && (txd == 1'b1);
  endtask

  task automatic settle();
    while (!temt) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_one(input logic [7:0] l, input logic [7:0] b,
                         output logic [7:0] d, output logic p, output bit ok);
    int t;
    settle();
    lcr = l;
    @(negedge clk);
    fork
      recv(l, d, p, ok, t);
      send(b);
    join
  endtask

  initial begin
    logic [7:0] d1, d2, l, b;
    logic       p1, p2;
    bit         ok1, ok2;
    int         t1, t2, cnt;
    logic [7:0] stop_cfg [4];

    void'($urandom(32'h1BAD5EED));
    rst_n = 1'b0; lcr = 8'h03; cts_gate_en = 1'b0; cts = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(txd == 1'b1, "R10", "txd after reset", int'(txd), 1);
    check(tx_ready == 1'b1, "R10", "ready after reset", int'(tx_ready), 1);
    check(temt == 1'b1, "R10", "temt after reset", int'(temt), 1);

    // R1 each word length, LSB first, upper bits dropped
    for (int w = 0; w < 4; w++) begin
      l = {6'b0, 2'(w)};
      run_one(l, 8'hB6, d1, p1, ok1);
      check(d1 == (8'hB6 & mask_of(l)), "R1", "word data", int'(d1), int'(8'hB6 & mask_of(l)));
      check(ok1, "R1", "start/stop framing", int'(ok1), 1);
    end

    // R2 odd and even parity, masked word
    run_one(8'h0B, 8'h07, d1, p1, ok1);
    check(p1 == 1'b0 && d1 == 8'h07, "R2", "odd parity of 0x07", int'(p1), 0);
    run_one(8'h1B, 8'h07, d1, p1, ok1);
    check(p1 == 1'b1, "R2", "even parity of 0x07", int'(p1), 1);
    run_one(8'h1A, 8'h81, d1, p1, ok1);
    check(p1 == 1'b1 && d1 == 8'h01, "R2", "even parity 7-bit ignores bit 7", int'(p1), 1);

    // R3 constant parity
    run_one(8'h2B, 8'h03, d1, p1, ok1);
    check(p1 == 1'b1, "R3", "mark parity", int'(p1), 1);
    run_one(8'h3B, 8'h01, d1, p1, ok1);
    check(p1 == 1'b0, "R3", "space parity", int'(p1), 0);

    // R4 stop length via back-to-back spacing
    stop_cfg[0] = 8'h03; stop_cfg[1] = 8'h04; stop_cfg[2] = 8'h07; stop_cfg[3] = 8'h0D;
    for (int s = 0; s < 4; s++) begin
      settle();
      l = stop_cfg[s];
      lcr = l;
      @(negedge clk);
      fork
        begin
          recv(l, d1, p1, ok1, t1);
          recv(l, d2, p2, ok2, t2);
        end
        begin
          send(8'h5C);
          send(8'hA3);
        end
      join
      check(t2 - t1 == frame_ticks(l), "R4", "start edge spacing", t2 - t1, frame_ticks(l));
      check(d2 == (8'hA3 & mask_of(l)) && ok2, "R4", "second queued frame", int'(d2),
            int'(8'hA3 & mask_of(l)));
    end

    // R1 R2 R3 random formats and tick rates
    for (int k = 0; k < 40; k++) begin
      l = 8'($urandom) & 8'hBF;
      b = 8'($urandom);
      tick_div = 1 + int'($urandom % 3);
      run_one(l, b, d1, p1, ok1);
      check(d1 == (b & mask_of(l)) && ok1, "R1", "random frame data", int'(d1), int'(b & mask_of(l)));
      if (l[3]) begin
        if (l[5]) check(p1 == exp_par(l, b), "R3", "random stick parity", int'(p1), int'(exp_par(l, b)));
        else check(p1 == exp_par(l, b), "R2", "random parity", int'(p1), int'(exp_par(l, b)));
      end
    end
    tick_div = 1;

    // R7 holding and empty flags
    settle();
    lcr = 8'h03;
    @(negedge clk);
    send(8'h96);
    check(tx_ready == 1'b0, "R7", "ready low after accept", int'(tx_ready), 0);
    @(negedge clk);
    check(tx_ready == 1'b1, "R7", "ready back while shifting", int'(tx_ready), 1);
    check(temt == 1'b0, "R7", "temt low while shifting", int'(temt), 0);
    recv(8'h03, d1, p1, ok1, t1);
    check(d1 == 8'h96, "R7", "frame data", int'(d1), 8'h96);
    repeat (20) @(negedge clk);
    check(temt == 1'b1, "R7", "temt high when done", int'(temt), 1);

    // R5 R6 break mid-frame with a byte waiting
    settle();
    lcr = 8'h03;
    @(negedge clk);
    fork
      begin
        while (txd !== 1'b0) @(negedge clk);
      end
      send(8'hA5);
    join
    repeat (40) @(negedge clk);
    lcr = 8'h43;
    send(8'h3C);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd) cnt = cnt + 1;
    end
    check(cnt == 0, "R5", "line spacing during break", cnt, 0);
    check(temt == 1'b0, "R6", "byte kept during break", int'(temt), 0);
    lcr = 8'h03;
    t1 = tick_count;
    @(negedge clk);
    recv(8'h03, d1, p1, ok1, t2);
    check(t2 - t1 >= 16, "R6", "mark gap after break", t2 - t1, 16);
    check(d1 == 8'h3C && ok1, "R6", "held byte sent, aborted dropped", int'(d1), 8'h3C);

    // R8 gate holds start; dropping mid-frame does not stop it
    settle();
    lcr = 8'h03;
    cts_gate_en = 1'b1;
    cts = 1'b0;
    @(negedge clk);
    send(8'h5A);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!txd) cnt = cnt + 1;
    end
    check(cnt == 0, "R8", "no start while cts low", cnt, 0);
    check(tx_ready == 1'b0 && temt == 1'b0, "R8", "byte waiting", int'(tx_ready), 0);
    fork
      recv(8'h03, d1, p1, ok1, t1);
      begin
        cts = 1'b1;
        repeat (80) @(negedge clk);
        cts = 1'b0;
      end
    join
    check(d1 == 8'h5A && ok1, "R8", "frame completes after cts drop", int'(d1), 8'h5A);

    // R9 gate disabled
    cts_gate_en = 1'b0;
    cts = 1'b0;
    run_one(8'h03, 8'hC3, d1, p1, ok1);
    check(d1 == 8'hC3 && ok1, "R9", "cts ignored when gate off", int'(d1), 8'hC3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule